// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, and moves data across in either direction. Each side owns a capture register with its own clock and its own synchronous reset. On every rising edge of its clock, a register samples the bus on its own side. The selects and enables have no say in that capture. For each direction, a select picks what goes onto the far bus: the live value of the near bus, or the value the near register last stored.

Two enables decide which bus the block actually drives. They have opposite active levels: the B-side enable is active high and the A-side enable is active low. With both enables at rest, both buses are isolated. Each bus is modelled as an input vector, an output vector and an output-enable bit, so a wrapper at a higher level can resolve the pins. With both directions enabled in live mode, each bus is driven from the other. Once every external source lets go, both buses keep their last value. With both selects on stored, the block drives the two stored words onto the opposite buses at the same time, which lets the buses exchange words.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A high `rst_a_cap` at a rising edge of `clk_a_cap` clears the A register to zero. A high `rst_b_cap` at a rising edge of `clk_b_cap` clears the B register to zero. A reset in one domain leaves the other register unchanged.
- R2: Each rising edge of `clk_a_cap` stores `a_in` into the A register, whatever the selects and enables are set to.
- R3: Each rising edge of `clk_b_cap` stores `b_in` into the B register, whatever the selects and enables are set to.
- R4: `b_oe` equals `drv_b_en`, which is active high. `a_oe` equals the inverse of `drv_a_en_n`, which is active low. The setting `drv_b_en`=0 with `drv_a_en_n`=1 drives neither bus.
- R5: With `b_src_stored`=0, `b_out` equals `a_in` bit for bit, uninverted, in the same cycle.
- R6: With `b_src_stored`=1, `b_out` equals the A register.
- R7: With `a_src_stored`=0, `a_out` equals `b_in` bit for bit, uninverted, in the same cycle.
- R8: With `a_src_stored`=1, `a_out` equals the B register.
- R9: An edge on one capture clock leaves the other side's register unchanged.
- R10: Set both enables active and both selects to live. If external drivers first set a value and then release both buses, both buses keep that value.
- R11: Set both enables active and both selects to stored. The block then drives the A register onto B and the B register onto A at the same time. If both clocks then capture at the same edge, the two registers swap contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_cap | input | 1 | Capture clock for the A-side register |
| rst_a_cap | input | 1 | Synchronous active-high reset, A-side domain |
| clk_b_cap | input | 1 | Capture clock for the B-side register |
| rst_b_cap | input | 1 | Synchronous active-high reset, B-side domain |
| drv_b_en | input | 1 | Active-high enable for driving bus B |
| drv_a_en_n | input | 1 | Active-low enable for driving bus A |
| b_src_stored | input | 1 | 1: B output carries the A register; 0: live A bus |
| a_src_stored | input | 1 | 1: A output carries the B register; 0: live B bus |
| a_in | input | WIDTH | Value seen on bus A |
| a_out | output | WIDTH | Value offered to bus A |
| a_oe | output | 1 | Bus A drive enable |
| b_in | input | WIDTH | Value seen on bus B |
| b_out | output | WIDTH | Value offered to bus B |
| b_oe | output | 1 | Bus B drive enable |

## Verification
The live paths and the drive enables are combinational, so their results appear in the same cycle as the stimulus. A stored value appears on the opposite output right after the rising capture edge that loads it, and no earlier. The bench changes inputs only while the clock is low and lets its bus model settle over a few short steps. It gates single capture edges and then compares at the following falling edge, after one more settling pass. Every comparison therefore sees exactly one register update for each pulsed clock, with the bus resolution complete.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;

   typedef enum logic {
      EN_ACT_HIGH = 1'b0,
      EN_ACT_LOW  = 1'b1
   } en_pol_e;

endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_cap_reg: WIDTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) q <= RST_VAL;
      else     q <= d;
   end

endmodule

// File: rtl/xcvr_dir_path.sv
module xcvr_dir_path
   import xcvr_pkg::*;
#(
   parameter int      WIDTH  = 8,
   parameter en_pol_e EN_POL = EN_ACT_HIGH
) (
   input  logic             en_pin,
   input  logic             sel,
   input  logic [WIDTH-1:0] live,
   input  logic [WIDTH-1:0] stored,
   output logic [WIDTH-1:0] dout,
   output logic             oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xcvr_dir_path: WIDTH must be at least 1");
   end

   src_sel_e src;
   assign src = src_sel_e'(sel);

   always_comb begin
      if (src == SRC_STORED) dout = stored;
      else                   dout = live;
   end

   if (EN_POL == EN_ACT_LOW) begin : g_en_low
      assign oe = ~en_pin;
   end else begin : g_en_high
      assign oe = en_pin;
   end

endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int               WIDTH   = 8,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_a_cap,
   input  logic             rst_a_cap,
   input  logic             clk_b_cap,
   input  logic             rst_b_cap,
   input  logic             drv_b_en,
   input  logic             drv_a_en_n,
   input  logic             b_src_stored,
   input  logic             a_src_stored,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_oe,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_oe
);

   if (WIDTH < 1) begin : g_bad_width
      $error("dual_reg_xcvr: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] a_held;
   logic [WIDTH-1:0] b_held;

   // A-side capture domain (R1, R2)
   xcvr_cap_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_reg_a (
      .clk (clk_a_cap),
      .rst (rst_a_cap),
      .d   (a_in),
      .q   (a_held)
   );

   // B-side capture domain (R1, R3)
   xcvr_cap_reg #(.WIDTH(WIDTH), .RST_VAL(RST_VAL)) u_reg_b (
      .clk (clk_b_cap),
      .rst (rst_b_cap),
      .d   (b_in),
      .q   (b_held)
   );

   // Toward bus B: active-high enable (R4, R5, R6)
   xcvr_dir_path #(.WIDTH(WIDTH), .EN_POL(EN_ACT_HIGH)) u_path_to_b (
      .en_pin (drv_b_en),
      .sel    (b_src_stored),
      .live   (a_in),
      .stored (a_held),
      .dout   (b_out),
      .oe     (b_oe)
   );

   // Toward bus A: active-low enable (R4, R7, R8)
   xcvr_dir_path #(.WIDTH(WIDTH), .EN_POL(EN_ACT_LOW)) u_path_to_a (
      .en_pin (drv_a_en_n),
      .sel    (a_src_stored),
      .live   (b_in),
      .stored (b_held),
      .dout   (a_out),
      .oe     (a_oe)
   );

endmodule

// File: rtl/dual_reg_xcvr_chk.sv
module dual_reg_xcvr_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk_a_cap,
   input logic             rst_a_cap,
   input logic             clk_b_cap,
   input logic             rst_b_cap,
   input logic             b_src_stored,
   input logic             a_src_stored,
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [WIDTH-1:0] a_out,
   input logic [WIDTH-1:0] b_out,
   input logic [WIDTH-1:0] a_held,
   input logic [WIDTH-1:0] b_held
);

   // R2
   cap_a_chk: assert property (@(posedge clk_a_cap) disable iff (rst_a_cap)
      1'b1 |=> (a_held == $past(a_in)));

   // R3
   cap_b_chk: assert property (@(posedge clk_b_cap) disable iff (rst_b_cap)
      1'b1 |=> (b_held == $past(b_in)));

   // R6
   stored_to_b_chk: assert property (@(posedge clk_a_cap) disable iff (rst_a_cap)
      1'b1 |=> (!b_src_stored || (b_out == $past(a_in))));

   // R8
   stored_to_a_chk: assert property (@(posedge clk_b_cap) disable iff (rst_b_cap)
      1'b1 |=> (!a_src_stored || (a_out == $past(b_in))));

endmodule

bind dual_reg_xcvr dual_reg_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
   .clk_a_cap    (clk_a_cap),
   .rst_a_cap    (rst_a_cap),
   .clk_b_cap    (clk_b_cap),
   .rst_b_cap    (rst_b_cap),
   .b_src_stored (b_src_stored),
   .a_src_stored (a_src_stored),
   .a_in         (a_in),
   .b_in         (b_in),
   .a_out        (a_out),
   .b_out        (b_out),
   .a_held       (a_held),
   .b_held       (b_held)
);

// File: tb/tb_dual_reg_xcvr.sv
`timescale 1ns/1ps
module tb_dual_reg_xcvr;

   localparam int W = 8;

   typedef struct packed {
      logic [3:0]   req;
      logic         en_b;
      logic         en_a_n;
      logic         sb;
      logic         sa;
      logic         ca;
      logic         cb;
      logic         ad;
      logic [W-1:0] av;
      logic         bd;
      logic [W-1:0] bv;
      logic [W-1:0] xa;
      logic [W-1:0] xb;
      logic         xaoe;
      logic         xboe;
   } vec_t;

   // Walked in order; register contents carry from row to row.
   localparam int NV = 10;
   localparam vec_t TBL [0:NV-1] = '{
      // R4 isolation, live paths both ways
      '{4'd4,  1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'hA5,1'b1,8'h3C,8'h3C,8'hA5,1'b0,1'b0},
      // R2 capture A while isolated, R6 stored to B
      '{4'd2,  1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,8'h5A,1'b1,8'hC3,8'hC3,8'h5A,1'b0,1'b0},
      // R3 capture B, R8 stored to A
      '{4'd3,  1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1,8'h11,1'b1,8'hE7,8'hE7,8'h5A,1'b0,1'b0},
      // R9 A edge leaves B register alone
      '{4'd9,  1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,8'h22,1'b1,8'h99,8'hE7,8'h22,1'b0,1'b0},
      // R5 live A drives bus B
      '{4'd5,  1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,8'h81,1'b0,8'h00,8'h81,8'h81,1'b0,1'b1},
      // R7 live B drives bus A
      '{4'd7,  1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,8'h7E,8'h7E,8'h7E,1'b1,1'b0},
      // R11 stored exchange with simultaneous capture: registers swap
      '{4'd11, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,8'h00,1'b0,8'h00,8'h22,8'hE7,1'b1,1'b1},
      // R10 both live, A driven externally
      '{4'd10, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h4B,1'b0,8'h00,8'h4B,8'h4B,1'b1,1'b1},
      // R10 external released, value held
      '{4'd10, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,8'h4B,8'h4B,1'b1,1'b1},
      // R2 capture while driving stored onto B
      '{4'd2,  1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,8'hF0,1'b0,8'h00,8'hF0,8'hF0,1'b0,1'b1}
   };

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic gate_a = 1'b0, gate_b = 1'b0;
   logic clk_a_cap, clk_b_cap;
   assign clk_a_cap = clk & gate_a;
   assign clk_b_cap = clk & gate_b;

   logic rst_a_cap = 1'b1, rst_b_cap = 1'b1;
   logic drv_b_en = 1'b0, drv_a_en_n = 1'b1;
   logic b_src_stored = 1'b0, a_src_stored = 1'b0;
   logic a_ext_drv = 1'b0, b_ext_drv = 1'b0;
   logic [W-1:0] a_ext = '0, b_ext = '0;
   logic [W-1:0] a_bus = '0, b_bus = '0;
   logic [W-1:0] a_out, b_out;
   logic a_oe, b_oe;

   dual_reg_xcvr #(.WIDTH(W)) dut (
      .clk_a_cap    (clk_a_cap),
      .rst_a_cap    (rst_a_cap),
      .clk_b_cap    (clk_b_cap),
      .rst_b_cap    (rst_b_cap),
      .drv_b_en     (drv_b_en),
      .drv_a_en_n   (drv_a_en_n),
      .b_src_stored (b_src_stored),
      .a_src_stored (a_src_stored),
      .a_in         (a_bus),
      .a_out        (a_out),
      .a_oe         (a_oe),
      .b_in         (b_bus),
      .b_out        (b_out),
      .b_oe         (b_oe)
   );

   int n_cmp = 0;
   int n_bad = 0;

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Bus model: external source wins, else block output when enabled, else hold.
   task automatic settle();
      for (int i = 0; i < 4; i++) begin
         a_bus = a_ext_drv ? a_ext : (a_oe ? a_out : a_bus);
         b_bus = b_ext_drv ? b_ext : (b_oe ? b_out : b_bus);
         #1;
      end
   endtask

   task automatic step(input logic ca, input logic cb);
      settle();
      gate_a = ca;
      gate_b = cb;
      @(posedge clk);
      @(negedge clk);
      gate_a = 1'b0;
      gate_b = 1'b0;
      settle();
   endtask

   initial begin
      #(20 * 100000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      // Reset both domains, then observe stored values (R1)
      @(negedge clk);
      b_src_stored = 1'b1; a_src_stored = 1'b1;
      a_ext_drv = 1'b1; a_ext = 8'h77;
      b_ext_drv = 1'b1; b_ext = 8'h66;
      step(1'b1, 1'b1);
      rst_a_cap = 1'b0; rst_b_cap = 1'b0;
      chk("R1", "b_out after reset", b_out, 8'h00);
      chk("R1", "a_out after reset", a_out, 8'h00);
      chk("R4", "a_oe at rest", {7'd0, a_oe}, 8'h00);
      chk("R4", "b_oe at rest", {7'd0, b_oe}, 8'h00);

      for (int k = 0; k < NV; k++) begin
         string rq;
         rq = $sformatf("R%0d row%0d", TBL[k].req, k);
         drv_b_en     = TBL[k].en_b;
         drv_a_en_n   = TBL[k].en_a_n;
         b_src_stored = TBL[k].sb;
         a_src_stored = TBL[k].sa;
         a_ext_drv    = TBL[k].ad;
         a_ext        = TBL[k].av;
         b_ext_drv    = TBL[k].bd;
         b_ext        = TBL[k].bv;
         step(TBL[k].ca, TBL[k].cb);
         chk(rq, "a_out", a_out, TBL[k].xa);
         chk(rq, "b_out", b_out, TBL[k].xb);
         chk(rq, "a_oe", {7'd0, a_oe}, {7'd0, TBL[k].xaoe});
         chk(rq, "b_oe", {7'd0, b_oe}, {7'd0, TBL[k].xboe});
      end

      // R10 directed: load both buses live, release, idle several cycles
      drv_b_en = 1'b1; drv_a_en_n = 1'b0;
      b_src_stored = 1'b0; a_src_stored = 1'b0;
      a_ext_drv = 1'b0; b_ext_drv = 1'b1; b_ext = 8'h6D;
      step(1'b0, 1'b0);
      b_ext_drv = 1'b0;
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk("R10", "bus A held", a_bus, 8'h6D);
      chk("R10", "bus B held", b_bus, 8'h6D);

      // R1 directed: reset A domain only; B register (22 after swap) survives
      drv_b_en = 1'b0; drv_a_en_n = 1'b1;
      b_src_stored = 1'b1; a_src_stored = 1'b1;
      a_ext_drv = 1'b1; a_ext = 8'hFF;
      b_ext_drv = 1'b1; b_ext = 8'h00;
      rst_a_cap = 1'b1;
      step(1'b1, 1'b0);
      rst_a_cap = 1'b0;
      chk("R1", "A register cleared", b_out, 8'h00);
      chk("R1", "B register kept", a_out, 8'h22);

      // R5/R7 live paths follow the buses with no clock edge
      b_src_stored = 1'b0; a_src_stored = 1'b0;
      a_ext = 8'h96; b_ext = 8'h0F;
      settle();
      chk("R5", "live b_out", b_out, 8'h96);
      chk("R7", "live a_out", a_out, 8'h0F);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule